// File: doc/BRIEF.md
# Output Ring Packet Buffer Writer

This block moves outbound packets into host receive buffers that software posts on a descriptor ring. Every descriptor supplies a buffer address and an info-area address. The block reads the packet length from the first word of a packet and works out how many buffers the packet will use. It waits until that many descriptors have been credited, then streams the packet as 8-byte memory writes. When one buffer fills, it pops the next descriptor and carries on in that buffer.

A per-ring mode bit chooses between two layouts. In info mode, only data goes into the buffers. The packet's total byte length is written once, into the info area of the first descriptor, and the rest of that info area is filled with zeros. In inline mode, the buffer carries a one-word length header ahead of the data, so the first buffer holds one data word less.

Each finished packet raises a pending count. The interrupt line rises when that count reaches a threshold, or when a timer reaches its limit. The timer only advances while at least one packet is unreported. An acknowledge input clears both the count and the timer.

Top module: `owr_ring_writer`

## Requirements
- R1: After reset, `wr_valid`, `in_ready`, `desc_pop` and `irq` are all 0.
- R2: With `cfg_info_mode`=1, a packet that fits in one buffer has its data word k written to buffer address + 8*k. Info word 0 is then written with the byte length, and info words 1..N-1 are written with zero, where N = `cfg_info_words`, or 1 if that field is 0.
- R3: With `cfg_info_mode`=1, a packet longer than `cfg_buf_words` words continues at offset 0 of the next descriptor's buffer once each buffer is full. Only the first descriptor's info area is written, and it holds the whole packet's length.
- R4: With `cfg_info_mode`=0, the first write of a packet goes to the buffer address and carries the byte length, zero-extended to 64 bits. Data word k then goes to buffer address + 8*(k+1).
- R5: With `cfg_info_mode`=0, the length header takes one word slot of the first buffer, so that buffer holds `cfg_buf_words`-1 data words. With `cfg_buf_words`=1, the header fills the whole first buffer.
- R6: Exactly one descriptor is popped for each buffer a packet touches. In info mode that is ceil(W/B) descriptors, and in inline mode ceil((W+1)/B), where W = ceil(len/8) and B = `cfg_buf_words`.
- R7: While the credited descriptor count is below what the waiting packet needs, `in_ready`, `desc_pop` and `wr_valid` all stay 0. The packet proceeds once `credit_add` pulses bring the credit count up to that need.
- R8: `irq` is 1 once the number of completed, unacknowledged packets is at least `cfg_cnt_thresh` and greater than 0.
- R9: With pending packets, `irq` rises once the timer reaches `cfg_time_thresh`. The timer does not advance while no packet is pending.
- R10: A one-cycle `irq_ack` clears the pending count and the timer, which drops `irq`.
- R11: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_info_mode | input | 1 | 1: info-area layout, 0: inline length header |
| cfg_buf_words | input | BW_W | Buffer size in 8-byte words (1..8192) |
| cfg_info_words | input | INFO_W | Info area size in 8-byte words (0 treated as 1, max 15) |
| cfg_cnt_thresh | input | CNT_W | Pending packet count that raises the interrupt |
| cfg_time_thresh | input | TMR_W | Timer value that raises the interrupt |
| in_valid | input | 1 | Packet word valid |
| in_ready | output | 1 | Packet word accepted |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_len | input | LEN_W | Packet byte length, valid with in_sop |
| in_data | input | DATA_W | Packet data word |
| desc_buf_addr | input | AW | Buffer address of the ring head descriptor |
| desc_info_addr | input | AW | Info-area address of the ring head descriptor |
| desc_pop | output | 1 | Consume the head descriptor |
| credit_add | input | 1 | Add credits this cycle |
| credit_cnt | input | CRD_W | Number of descriptors credited |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | DATA_W | Write data |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears count and timer |

## Verification
The assertions rely on several assumptions about the inputs:
- The head descriptor does not change except in the cycle after a pop.
- Software never credits more descriptors than the credit register can hold.
- The ring configuration stays fixed while a packet is in flight.
- `cfg_buf_words` is never zero.

The bench keeps within these limits. It models the ring as an index that advances one step after each observed pop. It credits exactly the number of descriptors each packet needs, computed from its own formula. It changes configuration only when no packet is in flight. It drives every input one time unit after the rising edge, so the head update and any stalls on `wr_ready` never coincide with the edge at which the design samples them.

// File: rtl/owr_pkg.sv
`timescale 1ns/1ps
package owr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_INFO = 2'd3
  } wr_state_e;

  // number of bus words occupied by len bytes
  function automatic int unsigned words_of(int unsigned len, int unsigned bytes);
    return (len + bytes - 1) / bytes;
  endfunction

  // buffers touched by a packet of w words with hdr header words
  function automatic int unsigned bufs_needed(int unsigned w, int unsigned hdr,
                                              int unsigned bw);
    return (w + hdr + bw - 1) / bw;
  endfunction

  // info words actually written (zero size still carries the length)
  function automatic int unsigned info_count(int unsigned iw);
    return (iw == 0) ? 1 : iw;
  endfunction

endpackage

// File: rtl/owr_credit.sv
`timescale 1ns/1ps
module owr_credit #(
  parameter int CRD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic [CRD_W-1:0] add_cnt,
  input  logic             take,
  output logic [CRD_W-1:0] level
);
  logic [CRD_W-1:0] add_amt;
  logic [CRD_W-1:0] take_amt;

  assign add_amt  = add  ? add_cnt : '0;
  assign take_amt = take ? CRD_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= level + add_amt - take_amt;
  end
endmodule

// File: rtl/owr_coalesce.sv
`timescale 1ns/1ps
module owr_coalesce #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_done,
  input  logic             ack,
  input  logic [CNT_W-1:0] cnt_th,
  input  logic [TMR_W-1:0] tmr_th,
  output logic [CNT_W-1:0] pend_cnt,
  output logic [TMR_W-1:0] tmr_val,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  logic pending;
  assign pending = (pend_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt <= '0;
      tmr_val  <= '0;
    end else if (ack) begin
      pend_cnt <= pkt_done ? CNT_W'(1) : '0;
      tmr_val  <= '0;
    end else begin
      if (pkt_done && pend_cnt != CNT_MAX) pend_cnt <= pend_cnt + CNT_W'(1);
      if (pending && tmr_val != TMR_MAX)   tmr_val  <= tmr_val + TMR_W'(1);
    end
  end

  assign irq = pending && ((pend_cnt >= cnt_th) || (tmr_val >= tmr_th));
endmodule

// File: rtl/owr_writer.sv
`timescale 1ns/1ps
module owr_writer
  import owr_pkg::*;
#(
  parameter int AW     = 48,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16,
  parameter int BW_W   = 14,
  parameter int INFO_W = 4,
  parameter int CRD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_info_mode,
  input  logic [BW_W-1:0]   cfg_buf_words,
  input  logic [INFO_W-1:0] cfg_info_words,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [AW-1:0]     desc_buf_addr,
  input  logic [AW-1:0]     desc_info_addr,
  input  logic [CRD_W-1:0]  credit_lvl,
  output logic              desc_pop,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pkt_done
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);

  wr_state_e         st;
  logic [AW-1:0]     buf_ptr, info_ptr;
  logic [BW_W-1:0]   off;
  logic [LEN_W-1:0]  len_q;
  logic [INFO_W-1:0] idx;
  logic              mode_q;

  // named internal events
  int unsigned       need;
  logic              start, buf_full, data_hs, info_last;
  logic [INFO_W-1:0] info_last_idx;

  assign need = bufs_needed(words_of(32'(in_len), BYTES),
                            cfg_info_mode ? 0 : 1, 32'(cfg_buf_words));
  assign start = (st == ST_IDLE) && in_valid && in_sop &&
                 (credit_lvl != '0) && (32'(credit_lvl) >= need);
  assign buf_full  = (st == ST_DATA) && (off == cfg_buf_words);
  assign data_hs   = (st == ST_DATA) && !buf_full && in_valid && wr_ready;
  assign info_last_idx = INFO_W'(info_count(32'(cfg_info_words)) - 1);
  assign info_last = (idx == info_last_idx);

  assign desc_pop = start || buf_full;
  assign in_ready = (st == ST_DATA) && !buf_full && wr_ready;
  assign pkt_done = (data_hs && in_eop && !mode_q) ||
                    ((st == ST_INFO) && wr_ready && info_last);

  always_comb begin
    wr_valid = 1'b0;
    wr_addr  = buf_ptr;
    wr_data  = in_data;
    unique case (st)
      ST_HDR: begin
        wr_valid = 1'b1;
        wr_data  = DATA_W'(len_q);
      end
      ST_DATA: begin
        wr_valid = in_valid && !buf_full;
        wr_addr  = buf_ptr + (AW'(off) << SH);
      end
      ST_INFO: begin
        wr_valid = 1'b1;
        wr_addr  = info_ptr + (AW'(idx) << SH);
        wr_data  = (idx == '0) ? DATA_W'(len_q) : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      buf_ptr  <= '0;
      info_ptr <= '0;
      off      <= '0;
      len_q    <= '0;
      idx      <= '0;
      mode_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          buf_ptr  <= desc_buf_addr;
          info_ptr <= desc_info_addr;
          len_q    <= in_len;
          off      <= '0;
          mode_q   <= cfg_info_mode;
          st       <= cfg_info_mode ? ST_DATA : ST_HDR;
        end
        ST_HDR: if (wr_ready) begin
          off <= BW_W'(1);
          st  <= ST_DATA;
        end
        ST_DATA: begin
          if (buf_full) begin
            buf_ptr <= desc_buf_addr;
            off     <= '0;
          end else if (data_hs) begin
            off <= off + BW_W'(1);
            if (in_eop) begin
              idx <= '0;
              st  <= mode_q ? ST_INFO : ST_IDLE;
            end
          end
        end
        ST_INFO: if (wr_ready) begin
          if (info_last) st <= ST_IDLE;
          else           idx <= idx + INFO_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owr_ring_writer.sv
`timescale 1ns/1ps
module owr_ring_writer #(
  parameter int AW        = 48,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 16,
  parameter int MAX_BUF_W = 8192,
  parameter int INFO_W    = 4,
  parameter int CRD_W     = 8,
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 16,
  localparam int BW_W     = $clog2(MAX_BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_info_mode,
  input  logic [BW_W-1:0]   cfg_buf_words,
  input  logic [INFO_W-1:0] cfg_info_words,
  input  logic [CNT_W-1:0]  cfg_cnt_thresh,
  input  logic [TMR_W-1:0]  cfg_time_thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AW-1:0]     desc_buf_addr,
  input  logic [AW-1:0]     desc_info_addr,
  output logic              desc_pop,
  input  logic              credit_add,
  input  logic [CRD_W-1:0]  credit_cnt,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              irq,
  input  logic              irq_ack
);
  logic [CRD_W-1:0] credit_lvl;
  logic             pkt_done;
  logic [CNT_W-1:0] pend_cnt;
  logic [TMR_W-1:0] tmr_val;

  owr_credit #(.CRD_W(CRD_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .add(credit_add), .add_cnt(credit_cnt),
    .take(desc_pop), .level(credit_lvl)
  );

  owr_writer #(
    .AW(AW), .DATA_W(DATA_W), .LEN_W(LEN_W), .BW_W(BW_W),
    .INFO_W(INFO_W), .CRD_W(CRD_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_n),
    .cfg_info_mode(cfg_info_mode), .cfg_buf_words(cfg_buf_words),
    .cfg_info_words(cfg_info_words),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_len(in_len),
    .in_data(in_data), .in_ready(in_ready),
    .desc_buf_addr(desc_buf_addr), .desc_info_addr(desc_info_addr),
    .credit_lvl(credit_lvl), .desc_pop(desc_pop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .pkt_done(pkt_done)
  );

  owr_coalesce #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_coalesce (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .ack(irq_ack),
    .cnt_th(cfg_cnt_thresh), .tmr_th(cfg_time_thresh),
    .pend_cnt(pend_cnt), .tmr_val(tmr_val), .irq(irq)
  );
endmodule

// File: rtl/owr_ring_writer_chk.sv
`timescale 1ns/1ps
module owr_ring_writer_chk #(
  parameter int AW     = 48,
  parameter int DATA_W = 64,
  parameter int CRD_W  = 8,
  parameter int CNT_W  = 8,
  parameter int TMR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              desc_pop,
  input logic [CRD_W-1:0]  credit_lvl,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              irq_ack,
  input logic              pkt_done,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [TMR_W-1:0]  tmr_val
);
  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R7
  pop_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_pop |-> (credit_lvl != '0));

  // R8
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_cnt != '0));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !pkt_done) |=> (pend_cnt == '0 && tmr_val == '0 && !irq));

  // R9
  tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == '0) |-> (tmr_val == '0));

  // R2
  flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> wr_valid);
endmodule

bind owr_ring_writer owr_ring_writer_chk #(
  .AW(AW), .DATA_W(DATA_W), .CRD_W(CRD_W), .CNT_W(CNT_W), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .desc_pop(desc_pop), .credit_lvl(credit_lvl), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
  .irq_ack(irq_ack), .pkt_done(pkt_done), .pend_cnt(pend_cnt),
  .tmr_val(tmr_val)
);

// File: tb/owr_ring_writer_tb.sv
`timescale 1ns/1ps
module owr_ring_writer_tb;
  localparam int AW = 48, DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           cfg_info_mode = 1'b1;
  logic [13:0]    cfg_buf_words = 14'd8;
  logic [3:0]     cfg_info_words = 4'd1;
  logic [7:0]     cfg_cnt_thresh = 8'hFF;
  logic [15:0]    cfg_time_thresh = 16'hFFFF;
  logic           in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [15:0]    in_len = '0;
  logic [DW-1:0]  in_data = '0;
  logic           in_ready, desc_pop, wr_valid, irq;
  logic [AW-1:0]  desc_buf_addr, desc_info_addr, wr_addr;
  logic [DW-1:0]  wr_data;
  logic           credit_add = 1'b0;
  logic [7:0]     credit_cnt = '0;
  logic           wr_ready = 1'b1;
  logic           irq_ack = 1'b0;

  owr_ring_writer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_info_mode(cfg_info_mode),
    .cfg_buf_words(cfg_buf_words), .cfg_info_words(cfg_info_words),
    .cfg_cnt_thresh(cfg_cnt_thresh), .cfg_time_thresh(cfg_time_thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_len(in_len), .in_data(in_data), .desc_buf_addr(desc_buf_addr),
    .desc_info_addr(desc_info_addr), .desc_pop(desc_pop),
    .credit_add(credit_add), .credit_cnt(credit_cnt), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
    .irq_ack(irq_ack)
  );

  int nchk = 0, nerr = 0;
  int didx = 0, pops_seen = 0, rec_n = 0, cyc = 0;
  bit pend_pop = 0, stall = 0, rdy_seen = 0;
  logic [AW-1:0] rec_a [64];
  logic [DW-1:0] rec_d [64];

  function automatic logic [AW-1:0] buf_of(int d);
    return AW'(48'h1000_0000 + 48'(d) * 48'h1_0000);
  endfunction
  function automatic logic [AW-1:0] info_of(int d);
    return AW'(48'h2000_0000 + 48'(d) * 48'h100);
  endfunction
  function automatic logic [DW-1:0] pat(int id, int w);
    return {16'hA5A5, 16'(id), 32'(w)};
  endfunction

  assign desc_buf_addr  = buf_of(didx);
  assign desc_info_addr = info_of(didx);

  // ring head model and write-port stall pattern, driven after the edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    if (pend_pop) begin didx++; pend_pop = 0; end
    wr_ready = !stall || (cyc % 3 != 0);
  end

  // observer, away from the active edge
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (wr_valid && wr_ready && rec_n < 64) begin
        rec_a[rec_n] = wr_addr; rec_d[rec_n] = wr_data; rec_n++;
      end
      if (desc_pop) begin pops_seen++; pend_pop = 1; end
      if (in_ready) rdy_seen = 1;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic add_credits(int n);
    credit_add = 1'b1; credit_cnt = 8'(n);
    tick(1);
    credit_add = 1'b0; credit_cnt = '0;
  endtask

  task automatic send_pkt(int len, int id);
    int words = (len + 7) / 8;
    for (int w = 0; w < words; w++) begin
      bit hs;
      in_valid = 1'b1; in_sop = (w == 0); in_eop = (w == words - 1);
      in_len = 16'(len); in_data = pat(id, w);
      do begin
        @(negedge clk); hs = in_ready;
        @(posedge clk); #1;
      end while (!hs);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  function automatic int need_of(bit mode, int bw, int len);
    return ((len + 7) / 8 + (mode ? 0 : 1) + bw - 1) / bw;
  endfunction

  // expected write list restated from the requirements
  task automatic verify(bit mode, int bw, int iw, int len, int id, int d0, string tag);
    logic [AW-1:0] ea [64];
    logic [DW-1:0] ed [64];
    int en = 0, d = d0, off = 0, bad = -1;
    int words = (len + 7) / 8;
    if (!mode) begin ea[en] = buf_of(d); ed[en] = DW'(len); en++; off = 1; end
    for (int w = 0; w < words; w++) begin
      if (off == bw) begin d++; off = 0; end
      ea[en] = buf_of(d) + AW'(off * 8); ed[en] = pat(id, w); en++; off++;
    end
    if (mode) for (int k = 0; k < ((iw == 0) ? 1 : iw); k++) begin
      ea[en] = info_of(d0) + AW'(k * 8); ed[en] = (k == 0) ? DW'(len) : '0; en++;
    end
    chk(rec_n == en, tag, "write count", rec_n, en);
    for (int i = 0; i < en && i < rec_n; i++)
      if (bad < 0 && (rec_a[i] !== ea[i] || rec_d[i] !== ed[i])) bad = i;
    if (bad >= 0) chk(0, tag, "write addr/data", longint'(rec_a[bad]), longint'(ea[bad]));
    else          chk(1, tag, "write addr/data", 0, 0);
    // R6
    chk(pops_seen == d - d0 + 1, "R6", "descriptor pops", pops_seen, d - d0 + 1);
  endtask

  task automatic run_pkt(bit mode, int bw, int iw, int len, bit st, int id, string tag);
    int d0;
    cfg_info_mode = mode; cfg_buf_words = 14'(bw); cfg_info_words = 4'(iw);
    stall = st;
    add_credits(need_of(mode, bw, len));
    rec_n = 0; pops_seen = 0; d0 = didx;
    send_pkt(len, id);
    tick(40);
    verify(mode, bw, iw, len, id, d0, st ? {tag, "/R11"} : tag);
    stall = 0;
  endtask

  // {mode[39:36], buf_words[35:20], info_words[19:16], len[15:0]}
  localparam logic [39:0] VEC [8] = '{
    {4'd1, 16'd8, 4'd2,  16'd20},
    {4'd1, 16'd4, 4'd1,  16'd60},
    {4'd1, 16'd2, 4'd3,  16'd33},
    {4'd0, 16'd8, 4'd0,  16'd16},
    {4'd0, 16'd4, 4'd0,  16'd24},
    {4'd0, 16'd4, 4'd0,  16'd25},
    {4'd0, 16'd1, 4'd0,  16'd9},
    {4'd1, 16'd1, 4'd15, 16'd8}
  };

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    string tags [8] = '{"R2", "R3", "R3", "R4", "R5", "R5", "R5", "R2"};
    tick(3);
    // R1 reset state
    chk(!wr_valid && !in_ready && !desc_pop && !irq, "R1", "reset outputs",
        {wr_valid, in_ready, desc_pop, irq}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!wr_valid && !in_ready && !desc_pop && !irq, "R1", "idle outputs",
        {wr_valid, in_ready, desc_pop, irq}, 0);

    for (int i = 0; i < 8; i++)
      run_pkt(VEC[i][36], int'(VEC[i][35:20]), int'(VEC[i][19:16]),
              int'(VEC[i][15:0]), i[0], i + 1, tags[i]);

    // R7 credit back-pressure
    begin
      int d0;
      cfg_info_mode = 1'b1; cfg_buf_words = 14'd2; cfg_info_words = 4'd1;
      rec_n = 0; pops_seen = 0; rdy_seen = 0; d0 = didx;
      fork
        send_pkt(24, 20);
        begin
          tick(20);
          chk(rec_n == 0 && pops_seen == 0 && !rdy_seen, "R7", "no credit stall",
              rec_n + pops_seen, 0);
          add_credits(1);
          tick(20);
          chk(rec_n == 0 && pops_seen == 0 && !rdy_seen, "R7", "partial credit stall",
              rec_n + pops_seen, 0);
          add_credits(1);
        end
      join
      tick(40);
      verify(1'b1, 2, 1, 24, 20, d0, "R7");
    end

    // R10 then R8 count threshold
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0; tick(1);
    chk(!irq, "R10", "irq after ack", irq, 0);
    cfg_cnt_thresh = 8'd3;
    run_pkt(1'b1, 8, 1, 8, 1'b0, 30, "R2");
    run_pkt(1'b1, 8, 1, 8, 1'b0, 31, "R2");
    chk(!irq, "R8", "irq below count", irq, 0);
    run_pkt(1'b1, 8, 1, 8, 1'b0, 32, "R2");
    chk(irq, "R8", "irq at count", irq, 1);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0; tick(1);
    chk(!irq, "R10", "irq cleared by ack", irq, 0);

    // R9 timer threshold
    cfg_cnt_thresh = 8'hFF; cfg_time_thresh = 16'd50;
    tick(60);
    chk(!irq, "R9", "timer idle without pending", irq, 0);
    run_pkt(1'b1, 8, 1, 8, 1'b0, 40, "R2");
    chk(!irq, "R9", "timer below limit", irq, 0);
    tick(20);
    chk(irq, "R9", "timer reached limit", irq, 1);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0; tick(1);
    chk(!irq, "R10", "timer irq cleared", irq, 0);

    finish_run();
  end
endmodule